// File: doc/BRIEF.md
# Packed SIMD Lane Shuffle Unit

This block rearranges the packed fields of one 128-bit vector operand. An 8-bit immediate and a 2-bit mode select what it does. The immediate holds four 2-bit selectors. Each selector names the source field that fills one destination field.

Two of the modes shuffle 16-bit words inside one 64-bit half and copy the other half unchanged. A third mode shuffles 32-bit fields across the whole operand. A fourth mode shuffles the four words of a 64-bit operand. Selectors may repeat, so one source field can be copied into several destinations. Running a half-word mode and then the doubleword mode broadcasts one word into all eight word positions. The result is registered and appears one clock after the request, together with a valid strobe.

Top module: `simd_lane_shuffle`

## Requirements
- R1: With mode 2'b00 (low-half word), result word i (bits [16i+15:16i], i = 0..3) equals source word s, where s is immediate bits [2i+1:2i]. Result bits [127:64] equal source bits [127:64].
- R2: With mode 2'b01 (high-half word), result word 4+i equals source word 4+s, where s is immediate bits [2i+1:2i]. Result bits [63:0] equal source bits [63:0].
- R3: With mode 2'b10 (doubleword), result field i (bits [32i+31:32i]) equals source field s, where s is immediate bits [2i+1:2i].
- R4: With mode 2'b11 (64-bit word), result word i equals source word s taken from bits [63:0], with s from immediate bits [2i+1:2i]. Result bits [127:64] are zero.
- R5: In mode 2'b11, immediate 8'h1B reverses the order of the four words.
- R6: Mode 2'b01 with immediate 8'hE5 copies word 5 into word 4 and leaves every other word unchanged. Passing that result through mode 2'b10 with immediate 8'hAA puts word 5 into all eight words.
- R7: out_valid equals in_valid delayed by one clock. A valid request's result appears on out_result in that same following cycle.
- R8: While rst_n is low at a clock edge, out_valid and out_result are both cleared to zero at that edge.
- R9: While in_valid is low, out_result keeps its previous value whatever the other inputs do.
- R10: In every mode, a selector value may appear more than once or not at all, and the same mapping rules still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_operand | input | 128 | Source vector |
| in_imm | input | 8 | Four 2-bit field selectors |
| in_mode | input | 2 | Operation select |
| out_valid | output | 1 | Result strobe |
| out_result | output | 128 | Shuffled vector |

## Verification
The only state in the block is the output register and its valid bit, so any internal fault shows at the ports in the cycle after the request that caused it. A selector decoded from the wrong immediate bits, or a field taken from the wrong half, gives a wrong word in that same result. Broken pass-through or zeroing shows as corrupted bits in the inactive half. A faulty load enable shows as a result that changes while in_valid is low. Because the bench compares every cycle, each of these faults is caught one clock after the stimulus that exposes it.

// File: rtl/shuf_pkg.sv
// Package: shared mode encoding for the lane shuffle unit.
// Assumes a 2-bit mode field; all four codes are defined.
package shuf_pkg;
    typedef enum logic [1:0] {
        SHUF_LO_WORD = 2'b00,
        SHUF_HI_WORD = 2'b01,
        SHUF_DWORD   = 2'b10,
        SHUF_W64     = 2'b11
    } shuf_mode_t;
endpackage

// File: rtl/shuf_field_perm.sv
// Module: shuf_field_perm
// Permutes NUM_F fields of FIELD_W bits. Each destination field takes the
// source field named by its selector slot. Purely combinational.
// Assumes NUM_F is a power of two, so every selector value is in range.
module shuf_field_perm #(
    parameter int FIELD_W = 16,
    parameter int NUM_F   = 4,
    localparam int SEL_W  = $clog2(NUM_F),
    localparam int VEC_W  = FIELD_W * NUM_F
) (
    input  logic [VEC_W-1:0]       src,
    input  logic [NUM_F*SEL_W-1:0] sel,
    output logic [VEC_W-1:0]       dst
);
    logic [FIELD_W-1:0] src_f [NUM_F];

    for (genvar j = 0; j < NUM_F; j++) begin : g_split
        // Unpack source field j.
        assign src_f[j] = src[j*FIELD_W +: FIELD_W];
    end

    for (genvar i = 0; i < NUM_F; i++) begin : g_pick
        // Destination field i chooses its source through selector slot i.
        assign dst[i*FIELD_W +: FIELD_W] = src_f[sel[i*SEL_W +: SEL_W]];
    end
endmodule

// File: rtl/shuf_result_mux.sv
// Module: shuf_result_mux
// Combines the half-word and doubleword permute outputs into the next result
// according to the mode: pass-through of the idle half, or zero upper half.
// Assumes DATA_W is even.
module shuf_result_mux
    import shuf_pkg::*;
#(
    parameter int DATA_W  = 128,
    localparam int HALF_W = DATA_W / 2
) (
    input  shuf_mode_t        mode,
    input  logic [DATA_W-1:0] src,
    input  logic [HALF_W-1:0] lo_perm,
    input  logic [HALF_W-1:0] hi_perm,
    input  logic [DATA_W-1:0] dw_perm,
    output logic [DATA_W-1:0] result
);
    // Select the full result for the active mode.
    always_comb begin
        unique case (mode)
            SHUF_LO_WORD: result = {src[DATA_W-1:HALF_W], lo_perm};
            SHUF_HI_WORD: result = {hi_perm, src[HALF_W-1:0]};
            SHUF_DWORD:   result = dw_perm;
            SHUF_W64:     result = {{HALF_W{1'b0}}, lo_perm};
            default:      result = '0;
        endcase
    end
endmodule

// File: rtl/simd_lane_shuffle.sv
// Module: simd_lane_shuffle (top)
// Registered single-operand field shuffle. The result is captured one clock
// after in_valid and held while in_valid is low.
// Assumes four fields per lane group, so the selector word is 4 x 2 bits.
module simd_lane_shuffle
    import shuf_pkg::*;
#(
    parameter int DATA_W   = 128,
    parameter int WORD_W   = 16,
    localparam int HALF_W  = DATA_W / 2,
    localparam int DWORD_W = 2 * WORD_W,
    localparam int NUM_F   = HALF_W / WORD_W,
    localparam int IMM_W   = NUM_F * $clog2(NUM_F)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_operand,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    logic [HALF_W-1:0] lo_perm, hi_perm;
    logic [DATA_W-1:0] dw_perm, next_result;

    shuf_field_perm #(.FIELD_W(WORD_W), .NUM_F(NUM_F)) u_lo_perm (
        .src(in_operand[HALF_W-1:0]), .sel(in_imm), .dst(lo_perm));

    shuf_field_perm #(.FIELD_W(WORD_W), .NUM_F(NUM_F)) u_hi_perm (
        .src(in_operand[DATA_W-1:HALF_W]), .sel(in_imm), .dst(hi_perm));

    shuf_field_perm #(.FIELD_W(DWORD_W), .NUM_F(NUM_F)) u_dw_perm (
        .src(in_operand), .sel(in_imm), .dst(dw_perm));

    shuf_result_mux #(.DATA_W(DATA_W)) u_mux (
        .mode(shuf_mode_t'(in_mode)), .src(in_operand),
        .lo_perm(lo_perm), .hi_perm(hi_perm), .dw_perm(dw_perm),
        .result(next_result));

    // Output register: clear on reset, load on request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_result <= next_result;
        end
    end
endmodule

// File: rtl/shuf_checker.sv
// Module: shuf_checker
// Temporal properties of the shuffle unit, observed at its ports.
// Bound to every simd_lane_shuffle instance.
module shuf_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [127:0] in_operand,
    input logic [7:0]   in_imm,
    input logic [1:0]   in_mode,
    input logic         out_valid,
    input logic [127:0] out_result
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_result == '0)); // R8

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid)); // R7

    AST_LO_MODE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(in_mode) == 2'b00)
        |-> out_result[127:64] == $past(in_operand[127:64])); // R1

    AST_HI_MODE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(in_mode) == 2'b01)
        |-> out_result[63:0] == $past(in_operand[63:0])); // R2

    AST_W64_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(in_mode) == 2'b11)
        |-> out_result[127:64] == 64'd0); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(out_result)); // R9
endmodule

bind simd_lane_shuffle shuf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .in_imm(in_imm), .in_mode(in_mode), .out_valid(out_valid),
    .out_result(out_result));

// File: tb/simd_lane_shuffle_tb.sv
module simd_lane_shuffle_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_operand = '0;
    logic [7:0]   in_imm = '0;
    logic [1:0]   in_mode = '0;
    logic         out_valid;
    logic [127:0] out_result;

    int n_cmp = 0;
    int n_bad = 0;
    logic         exp_valid = 1'b0;
    logic [127:0] exp_result = '0;

    always #4 clk = ~clk; // 125 MHz

    simd_lane_shuffle u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .in_imm(in_imm), .in_mode(in_mode), .out_valid(out_valid),
        .out_result(out_result));

    // Behavioural reference: walks destination fields with integer indices.
    function automatic logic [127:0] ref_shuffle(logic [127:0] op, logic [7:0] imm,
                                                 logic [1:0] mode);
        logic [127:0] r;
        r = op;
        if (mode == 2'b11) r = '0;
        for (int i = 0; i < 4; i++) begin
            int s;
            s = (imm >> (2 * i)) & 3;
            case (mode)
                2'b00, 2'b11: r[16*i +: 16]      = op[16*s +: 16];
                2'b01:        r[64+16*i +: 16]   = op[64+16*s +: 16];
                default:      r[32*i +: 32]      = op[32*s +: 32];
            endcase
        end
        return r;
    endfunction

    task automatic check(string tag, logic [128:0] act, logic [128:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model, compare at next negedge.
    task automatic step(string tag, logic v, logic [127:0] op, logic [7:0] imm,
                        logic [1:0] mode, logic rst_val = 1'b1);
        rst_n = rst_val; in_valid = v; in_operand = op; in_imm = imm; in_mode = mode;
        if (!rst_val) begin
            exp_valid = 1'b0; exp_result = '0;
        end else begin
            exp_valid = v;
            if (v) exp_result = ref_shuffle(op, imm, mode);
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, {out_valid, out_result}, {exp_valid, exp_result});
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] seq_op;
        for (int i = 0; i < 8; i++) seq_op[16*i +: 16] = 16'hA000 + 16'(i);
        @(negedge clk);
        // R8: reset holds everything at zero even with a request present.
        step("R8 reset", 1'b1, rnd128(), 8'hE4, 2'b10, 1'b0);
        step("R8 reset", 1'b0, '0, 8'h00, 2'b00, 1'b0);
        // R5: 64-bit word reversal.
        step("R5 reverse", 1'b1, seq_op, 8'h1B, 2'b11);
        check("R5 reverse words", {1'b0, out_result},
              {1'b0, 64'd0, 16'hA000, 16'hA001, 16'hA002, 16'hA003});
        // R6: two-pass broadcast of word 5.
        step("R6 pass one", 1'b1, seq_op, 8'hE5, 2'b01);
        check("R6 copy word5", {1'b0, out_result},
              {1'b0, 16'hA007, 16'hA006, 16'hA005, 16'hA005,
               16'hA003, 16'hA002, 16'hA001, 16'hA000});
        step("R6 pass two", 1'b1, out_result, 8'hAA, 2'b10);
        check("R6 broadcast", {1'b0, out_result}, {1'b0, {8{16'hA005}}});
        // R10: repeated selectors in each mode.
        for (int m = 0; m < 4; m++)
            step("R10 repeat sel", 1'b1, rnd128(), 8'h00, 2'(m));
        // R1 R2 R3 R4: identity selector in each mode.
        step("R1 identity", 1'b1, rnd128(), 8'hE4, 2'b00);
        step("R2 identity", 1'b1, rnd128(), 8'hE4, 2'b01);
        step("R3 identity", 1'b1, rnd128(), 8'hE4, 2'b10);
        step("R4 identity", 1'b1, rnd128(), 8'hE4, 2'b11);
        // R9: idle cycles with changing inputs hold the result.
        for (int k = 0; k < 4; k++)
            step("R9 hold", 1'b0, rnd128(), 8'($urandom), 2'($urandom));
        // R7: mid-stream reset, then random traffic.
        step("R8 mid reset", 1'b1, rnd128(), 8'h39, 2'b00, 1'b0);
        for (int k = 0; k < 400; k++) begin
            logic [1:0] m;
            logic v;
            m = 2'($urandom);
            v = ($urandom % 4) != 0;
            case ({v, m})
                3'b100:  step("R1 random", v, rnd128(), 8'($urandom), m);
                3'b101:  step("R2 random", v, rnd128(), 8'($urandom), m);
                3'b110:  step("R3 random", v, rnd128(), 8'($urandom), m);
                3'b111:  step("R4 random", v, rnd128(), 8'($urandom), m);
                default: step("R7 R9 idle", v, rnd128(), 8'($urandom), m);
            endcase
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule